// File: doc/BRIEF.md
# Serial Wiper Register Front End

This block is the digital side of a four-channel digital potentiometer. A host writes wiper codes over a three-wire serial port: an active-low select, a serial clock and a data line. Each frame is ten bits, a two-bit channel index followed by an eight-bit code, sent most significant bit first. The port pins are brought into the system clock domain through a synchronizer, and serial clock edges are detected there. Then the frame is shifted in on serial clock rises. The addressed register takes the code when select is released, but only if the frame held exactly ten clocks.

A serial output replays the most significant bit of the shift register on every falling serial clock edge. An upstream frame therefore appears at the output ten clocks later, so devices can be chained. Each committed write raises a one-cycle strobe in the system clock domain, together with the channel index. All channels come out of reset at midscale.

The system clock must run fast enough that each serial clock phase lasts at least three system clock periods.

Top module: `wiper_serial_if`

## Requirements
- R1: After reset every channel reads 0x80, the update strobe is low and the serial output is low.
- R2: A frame of exactly ten rising serial clock edges while select is low carries the channel index in its first two bits and the code in the last eight bits, MSB first. When select rises, the wiper output for that channel takes the code. The data line is sampled only at the rising serial clock edge; changes while the clock is high have no effect.
- R3: A committed write changes no channel other than the addressed one.
- R4: A wiper output never changes while select is low; it changes only at a commit following a select rise.
- R5: A frame with fewer or more than ten rising edges is discarded on select rise, and no register or strobe changes.
- R6: Each commit raises the update strobe for exactly one system clock cycle, with the written channel on the channel output. The strobe never rises at any other time.
- R7: The serial output changes only after a falling serial clock edge, and then shows the shift register MSB. This is the bit received ten rising edges earlier in the frame, or 0 during the first nine.
- R8: Raising select clears the shift register and bit count, so an aborted partial frame does not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from host |
| spi_cs_ni | input | 1 | Active-low frame select |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out for chaining |
| wiper_o | output | 32 | Wiper codes, channel n at bits 8n+7:8n |
| upd_o | output | 1 | One-cycle commit strobe |
| upd_ch_o | output | 2 | Channel written at the strobe |

## Verification
The hardest case to reach is a frame of the wrong length that otherwise looks valid. If it were not discarded, it would commit a plausible code to a plausible channel. The stimulus sends directed nine- and eleven-clock frames and a frame aborted halfway, each followed by a clean frame. Random frames also sometimes have a length between eight and twelve bits. Data is deliberately corrupted while the serial clock is high, which shows that only the rising-edge value counts. The serial output is compared after every fall against a model of the ten-bit shift register.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int WPR_ADDR_W      = 2;
  localparam int WPR_DATA_W      = 8;
  localparam int WPR_SYNC_STAGES = 2;
  localparam logic [WPR_DATA_W-1:0] WPR_RESET_CODE = 8'h80;
endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= RESET_VAL;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= RESET_VAL;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wpr_shifter.sv
module wpr_shifter #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_n_s_i,
  input  logic              sdi_s_i,
  output logic              sdo_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cs_rise_o,
  output logic              sclk_fall_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sclk_q, cs_n_q, sdo_q;
  logic               sclk_rise;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_n_q <= cs_n_s_i;
    end

  assign sclk_rise   = sclk_s_i & ~sclk_q & ~cs_n_s_i;
  assign sclk_fall_o = ~sclk_s_i & sclk_q;
  assign cs_rise_o   = cs_n_s_i & ~cs_n_q;

  // select high holds the frame state cleared
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (cs_n_s_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (sclk_rise) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s_i};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          sdo_q <= 1'b0;
    else if (sclk_fall_o) sdo_q <= shreg_q[FRAME_W-1];

  assign sdo_o    = sdo_q;
  assign commit_o = cs_rise_o && (cnt_q == CNT_FULL);
  assign addr_o   = shreg_q[FRAME_W-1 -: ADDR_W];
  assign data_o   = shreg_q[DATA_W-1:0];
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wpr_bank.sv
module wpr_bank #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_CODE = '0,
  localparam int NUM_CH = 1 << ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic                     upd_o,
  output logic [ADDR_W-1:0]        upd_ch_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                   code_q <= RESET_CODE;
      else if (we_i && (addr_i == ADDR_W'(g)))       code_q <= data_i;
    assign wiper_o[g*DATA_W +: DATA_W] = code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      upd_o    <= 1'b0;
      upd_ch_o <= '0;
    end else begin
      upd_o <= we_i;
      if (we_i) upd_ch_o <= addr_i;
    end
endmodule

// File: rtl/wiper_serial_if.sv
module wiper_serial_if
  import wpr_pkg::*;
#(
  parameter int ADDR_W = WPR_ADDR_W,
  parameter int DATA_W = WPR_DATA_W,
  parameter int SYNC_STAGES = WPR_SYNC_STAGES,
  parameter logic [DATA_W-1:0] RESET_CODE = WPR_RESET_CODE,
  localparam int NUM_CH = 1 << ADDR_W,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     spi_sclk_i,
  input  logic                     spi_cs_ni,
  input  logic                     spi_sdi_i,
  output logic                     spi_sdo_o,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic                     upd_o,
  output logic [ADDR_W-1:0]        upd_ch_o
);
  logic              sclk_s, cs_n_s, sdi_s;
  logic              commit, cs_rise, sclk_fall;
  logic [ADDR_W-1:0] frame_addr;
  logic [DATA_W-1:0] frame_data;
  logic [CNT_W-1:0]  bit_cnt;

  wpr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_sclk_i, spi_cs_ni, spi_sdi_i}),
    .q_o   ({sclk_s, cs_n_s, sdi_s})
  );

  wpr_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .cs_n_s_i   (cs_n_s),
    .sdi_s_i    (sdi_s),
    .sdo_o      (spi_sdo_o),
    .commit_o   (commit),
    .addr_o     (frame_addr),
    .data_o     (frame_data),
    .cs_rise_o  (cs_rise),
    .sclk_fall_o(sclk_fall),
    .cnt_o      (bit_cnt)
  );

  wpr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_CODE(RESET_CODE)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .addr_i  (frame_addr),
    .data_i  (frame_data),
    .wiper_o (wiper_o),
    .upd_o   (upd_o),
    .upd_ch_o(upd_ch_o)
  );
endmodule

// File: rtl/wiper_serial_if_chk.sv
module wiper_serial_if_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  localparam int NUM_CH = 1 << ADDR_W,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_W + 2)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     upd_i,
  input logic [ADDR_W-1:0]        upd_ch_i,
  input logic [NUM_CH*DATA_W-1:0] wiper_i,
  input logic                     sdo_i,
  input logic                     sclk_fall_i,
  input logic                     cs_rise_i,
  input logic [CNT_W-1:0]         bit_cnt_i
);
  logic [NUM_CH*DATA_W-1:0] wiper_q;
  logic [NUM_CH-1:0]        chg;

  always_ff @(posedge clk_i) wiper_q <= wiper_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chg
    assign chg[g] = wiper_i[g*DATA_W +: DATA_W] != wiper_q[g*DATA_W +: DATA_W];
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i); // R6
  AST_STROBE_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> $past(cs_rise_i)); // R6
  AST_FULL_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> ($past(bit_cnt_i) == CNT_W'(FRAME_W))); // R5
  AST_WIPER_NEEDS_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg != '0) |-> upd_i); // R4
  AST_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> ((chg & ~(NUM_CH'(1) << upd_ch_i)) == '0)); // R3
  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_i) |-> $past(sclk_fall_i)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(FRAME_W + 1)); // R5
endmodule

bind wiper_serial_if wiper_serial_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_i      (upd_o),
  .upd_ch_i   (upd_ch_o),
  .wiper_i    (wiper_o),
  .sdo_i      (spi_sdo_o),
  .sclk_fall_i(sclk_fall),
  .cs_rise_i  (cs_rise),
  .bit_cnt_i  (bit_cnt)
);

// File: tb/wiper_serial_if_bench.sv
module wiper_serial_if_bench;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic        sdo, upd;
  logic [1:0]  upd_ch;
  logic [31:0] wiper;

  int checks = 0, fails = 0;
  int strobe_cnt = 0, double_cnt = 0;
  logic [1:0] last_ch = '0;
  logic prev_upd = 1'b0;
  bit done = 0;

  logic [7:0] exp_w [4];
  logic [9:0] model;
  int         exp_strobes = 0;
  logic [1:0] exp_ch = '0;

  always #4 clk = ~clk;

  wiper_serial_if u_wiper_serial_if (
    .clk_i(clk), .rst_ni(rst_ni), .spi_sclk_i(sclk), .spi_cs_ni(cs_n),
    .spi_sdi_i(sdi), .spi_sdo_o(sdo), .wiper_o(wiper), .upd_o(upd), .upd_ch_o(upd_ch)
  );

  always @(negedge clk) begin
    if (upd) begin
      strobe_cnt++;
      last_ch = upd_ch;
      if (prev_upd) double_cnt++;
    end
    prev_upd = upd;
  end

  function automatic logic [9:0] frame_word(input logic [1:0] a, input logic [7:0] d);
    return {a, d};
  endfunction

  function automatic logic [9:0] shift_in(input logic [9:0] s, input logic b);
    return {s[8:0], b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bank(input string req);
    for (int c = 0; c < 4; c++) check(req, wiper[c*8 +: 8], exp_w[c]);
  endtask

  // send nbits from vec, MSB first; optional early abort is just a short frame
  task automatic send(input int nbits, input logic [15:0] vec);
    cs_n = 1'b0;
    model = '0;
    wait_clk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = vec[i];
      wait_clk(HALF);
      sclk = 1'b1;
      model = shift_in(model, vec[i]);
      wait_clk(2);
      sdi = $urandom_range(0, 1); // R2: junk while clock high
      wait_clk(HALF - 2);
      sclk = 1'b0;
      wait_clk(HALF);
      check("R7", {31'd0, sdo}, {31'd0, model[9]});
    end
    check_bank("R4");
    cs_n = 1'b1;
    if (nbits == 10) begin
      exp_w[model[9:8]] = model[7:0];
      exp_strobes++;
      exp_ch = model[9:8];
    end
    wait_clk(3 * HALF);
    check_bank(nbits == 10 ? "R2/R3" : "R5");
    check("R6", strobe_cnt, exp_strobes);
    check("R6", {30'd0, last_ch}, {30'd0, exp_ch});
    check("R6", double_cnt, 0);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) exp_w[c] = 8'h80;
    void'($urandom(32'h5eed_1234));
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    check_bank("R1");
    check("R1", {31'd0, upd}, 0);
    check("R1", {31'd0, sdo}, 0);
    check("R1", strobe_cnt, 0);

    for (int c = 0; c < 4; c++) send(10, {6'd0, frame_word(2'(c), 8'(8'h11 * (c + 3)))}); // R2 R3
    send(10, {6'd0, frame_word(2'd1, 8'h00)});
    send(10, {6'd0, frame_word(2'd2, 8'hFF)});
    send(9,  16'h01A5);                       // R5 short
    send(11, {5'd0, 1'b1, frame_word(2'd3, 8'h5A)}); // R5 long
    send(4,  16'h000F);                       // R8 aborted
    send(10, {6'd0, frame_word(2'd0, 8'hC3)}); // R8 clean after abort
    send(10, {6'd0, frame_word(2'd0, 8'hC3)}); // same value again
    for (int k = 0; k < 40; k++) begin
      int n;
      n = ($urandom_range(0, 3) == 0) ? $urandom_range(8, 12) : 10;
      send(n, 16'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule